// File: doc/BRIEF.md
# AES Round-Key Sequencer

This block expands an AES cipher key of 128, 192 or 256 bits into the full round-key schedule. It hands the keys to a round engine one 128-bit word at a time. A load strobe captures the cipher key and its size code. In the next cycle the first round key is on the output with its valid flag set. After that, every cycle in which the engine raises `advance_i` while the key is valid brings the next round key one clock later. When `advance_i` stays high, the engine gets one key per cycle with no gaps, for every key size.

The hard case is the 192-bit key. Its schedule grows in six-word (192-bit) chunks, but the output is four words wide. The sequencer steps through three phases. In the first phase it emits four words of a chunk and holds the remaining two. In the second phase it expands a new chunk, emits the two held words in front of that chunk's first two words, and holds the other four. In the third phase it emits the four held words while the expansion logic pauses. The 256-bit schedule is produced one 128-bit half at a time. The halves alternate between a rotate-substitute-constant step and a substitute-only step. The final round key is also kept on its own output, with its own flag, until the next load.

States:
- `ST_IDLE`: after reset.
- `ST_K128`: 128-bit schedule.
- `ST_K192_P1`, `ST_K192_P2`, `ST_K192_P0`: the three phases of the 192-bit schedule.
- `ST_K256_RAW`: the second cipher-key half.
- `ST_K256_ROT`, `ST_K256_SUB`: the two alternating 256-bit steps.
- `ST_DONE`: the whole schedule has been consumed.

Transitions:
- A load goes to `ST_K128`, `ST_K192_P1` or `ST_K256_RAW`, from any state.
- An accepted advance steps P1→P2→P0→P1, RAW→ROT→SUB→ROT, or stays in `ST_K128`.
- Accepting the last key goes to `ST_DONE`.

Top module: `aes_key_sched`

## Requirements
- R1: The size code `ksize_i` selects the number of round keys: 2'b00 gives 11, 2'b01 gives 13, 2'b10 gives 15. The unused code 2'b11 behaves like 2'b00.
- R2: One cycle after `load_i`, `rk_o` equals `key_i[255:128]` with `rk_valid_o` high. A 192-bit key sits in `key_i[255:64]`. A 128-bit key sits in `key_i[255:128]`.
- R3: While `rk_valid_o` is high, each cycle with `advance_i` high brings the next round key one cycle later, so a held `advance_i` delivers one key per cycle.
- R4: While `rk_valid_o` is high and `advance_i` and `load_i` are low, `rk_o` and `rk_valid_o` stay unchanged.
- R5: `rk_last_o` is high only while the final round key is presented. Accepting that key drops `rk_valid_o`. A later `advance_i` has no effect.
- R6: With a 128-bit key, the keys are the standard AES-128 schedule. Each key is the previous key with a rotated, substituted, round-constant word chained into it.
- R7: With a 192-bit key, the keys are the standard AES-192 schedule, packed four words per key in schedule order.
- R8: With a 256-bit key, the keys are the standard AES-256 schedule. The second key is `key_i[127:0]`. After that, the steps alternate between rotate-substitute-constant and substitute-only.
- R9: `final_valid_o` rises together with the presentation of the final round key. `final_key_o` then equals that key and holds until the next load.
- R10: `load_i` restarts the schedule from any state, takes priority over `advance_i`, and clears `final_valid_o`.
- R11: After reset, `rk_valid_o`, `rk_last_o` and `final_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_i | input | 256 | Cipher key, left-aligned |
| ksize_i | input | 2 | Key size code |
| load_i | input | 1 | Capture key and start a schedule |
| advance_i | input | 1 | Engine accepts the presented key |
| rk_o | output | 128 | Current round key |
| rk_valid_o | output | 1 | `rk_o` holds a key |
| rk_last_o | output | 1 | `rk_o` is the final key |
| final_key_o | output | 128 | Final round key |
| final_valid_o | output | 1 | `final_key_o` is valid |

## Verification
The block has no top-level parameters, because AES fixes the key and word widths, so the bench builds it exactly as delivered. Random keys are run with random advance patterns across all four size codes. This reaches every phase of the 192-bit repacking, the pause in phase P0, stalls in each phase, and both alternating 256-bit steps. Directed runs cover a known AES-128 vector, a reload with `advance_i` high in the middle of a 192-bit schedule, and extra advances after the end.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

    localparam int WORD_W  = 32;
    localparam int RK_WORDS = 4;
    localparam int RK_W    = WORD_W * RK_WORDS;
    localparam int KEY_W   = 2 * RK_W;
    localparam int CNT_W   = 4;

    localparam logic [1:0] KS_128 = 2'b00;
    localparam logic [1:0] KS_192 = 2'b01;
    localparam logic [1:0] KS_256 = 2'b10;

    localparam logic [CNT_W-1:0] LAST_128 = CNT_W'(10);
    localparam logic [CNT_W-1:0] LAST_192 = CNT_W'(12);
    localparam logic [CNT_W-1:0] LAST_256 = CNT_W'(14);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_K128,
        ST_K192_P0,
        ST_K192_P1,
        ST_K192_P2,
        ST_K256_RAW,
        ST_K256_ROT,
        ST_K256_SUB,
        ST_DONE
    } kx_state_e;

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = gf_dbl(aa);
        end
        return acc;
    endfunction

    // a^254 is the multiplicative inverse (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < 7; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
        logic [15:0] d;
        d = {b, b} << k;
        return d[15:8];
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [WORD_W-1:0] sub_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W / 8; i++) begin
            r[i*8 +: 8] = sbox(w[i*8 +: 8]);
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
        return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
    endfunction

endpackage

// File: rtl/kx_gword.sv
// Word transform of the schedule: optional byte rotate, byte substitution,
// optional round constant in the top byte.
module kx_gword
    import aes_kx_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [7:0]        rcon_i,
    input  logic              rot_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] pre;
    logic [WORD_W-1:0] subbed;

    always_comb begin
        pre    = rot_i ? rot_word(word_i) : word_i;
        subbed = sub_word(pre);
        word_o = subbed ^ {(rot_i ? rcon_i : 8'h00), {(WORD_W-8){1'b0}}};
    end
endmodule

// File: rtl/kx_xor_chain.sv
// Chained XOR of a schedule chunk: first word takes the transformed word,
// each later word takes the freshly produced word before it. Word 0 is MSB.
module kx_xor_chain
    import aes_kx_pkg::*;
#(
    parameter int NW = 4
) (
    input  logic [NW*WORD_W-1:0] prev_i,
    input  logic [WORD_W-1:0]    lead_i,
    output logic [NW*WORD_W-1:0] next_o
);
    for (genvar gi = 0; gi < NW; gi++) begin : g_w
        localparam int HI = NW*WORD_W - 1 - gi*WORD_W;
        logic [WORD_W-1:0] w;
        if (gi == 0) begin : g_head
            assign w = prev_i[HI -: WORD_W] ^ lead_i;
        end else begin : g_tail
            assign w = prev_i[HI -: WORD_W] ^ g_w[gi-1].w;
        end
        assign next_o[HI -: WORD_W] = w;
    end
endmodule

// File: rtl/aes_key_sched.sv
module aes_key_sched
    import aes_kx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key_i,
    input  logic [1:0]       ksize_i,
    input  logic             load_i,
    input  logic             advance_i,
    output logic [RK_W-1:0]  rk_o,
    output logic             rk_valid_o,
    output logic             rk_last_o,
    output logic [RK_W-1:0]  final_key_o,
    output logic             final_valid_o
);
    localparam int C6_W = 6 * WORD_W;

    kx_state_e          state_q, state_d;
    logic [RK_W-1:0]    rk_q, hold_q, final_q, nxt_rk;
    logic [KEY_W-1:0]   win_q;
    logic [7:0]         rcon_q;
    logic [CNT_W-1:0]   cnt_q, last_idx_q, cnt_nxt;
    logic               final_v_q;
    logic               rk_valid, rk_last, take;
    logic               in192, in256;

    logic [WORD_W-1:0]  g_in, g_out;
    logic               g_rot;
    logic [RK_W-1:0]    c4_prev, c4;
    logic [C6_W-1:0]    c6;

    assign rk_valid = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign rk_last  = rk_valid && (cnt_q == last_idx_q);
    assign take     = rk_valid && advance_i;
    assign cnt_nxt  = cnt_q + CNT_W'(1);
    assign in192    = (state_q == ST_K192_P0) || (state_q == ST_K192_P1) || (state_q == ST_K192_P2);
    assign in256    = (state_q == ST_K256_ROT) || (state_q == ST_K256_SUB);

    // one shared word transform for all key sizes
    assign g_in    = in192 ? win_q[KEY_W-6*WORD_W +: WORD_W] : rk_q[WORD_W-1:0];
    assign g_rot   = (state_q != ST_K256_SUB);
    assign c4_prev = in256 ? win_q[KEY_W-1 -: RK_W] : rk_q;

    kx_gword u_gword (
        .word_i (g_in),
        .rcon_i (rcon_q),
        .rot_i  (g_rot),
        .word_o (g_out)
    );

    kx_xor_chain #(.NW(4)) u_chain4 (
        .prev_i (c4_prev),
        .lead_i (g_out),
        .next_o (c4)
    );

    kx_xor_chain #(.NW(6)) u_chain6 (
        .prev_i (win_q[KEY_W-1 -: C6_W]),
        .lead_i (g_out),
        .next_o (c6)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            unique case (ksize_i)
                KS_192:  state_d = ST_K192_P1;
                KS_256:  state_d = ST_K256_RAW;
                default: state_d = ST_K128;
            endcase
        end else if (take) begin
            if (rk_last) begin
                state_d = ST_DONE;
            end else begin
                unique case (state_q)
                    ST_K192_P1:  state_d = ST_K192_P2;
                    ST_K192_P2:  state_d = ST_K192_P0;
                    ST_K192_P0:  state_d = ST_K192_P1;
                    ST_K256_RAW: state_d = ST_K256_ROT;
                    ST_K256_ROT: state_d = ST_K256_SUB;
                    ST_K256_SUB: state_d = ST_K256_ROT;
                    default:     state_d = state_q;
                endcase
            end
        end
    end

    // next round key per state
    always_comb begin
        unique case (state_q)
            ST_K128, ST_K256_ROT, ST_K256_SUB: nxt_rk = c4;
            ST_K256_RAW: nxt_rk = win_q[RK_W-1:0];
            ST_K192_P1:  nxt_rk = {hold_q[RK_W-1 -: 2*WORD_W], c6[C6_W-1 -: 2*WORD_W]};
            ST_K192_P2:  nxt_rk = hold_q;
            ST_K192_P0:  nxt_rk = c6[C6_W-1 -: RK_W];
            default:     nxt_rk = rk_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rk_q       <= '0;
            hold_q     <= '0;
            win_q      <= '0;
            rcon_q     <= 8'h01;
            cnt_q      <= '0;
            last_idx_q <= LAST_128;
            final_q    <= '0;
            final_v_q  <= 1'b0;
        end else if (load_i) begin
            rk_q      <= key_i[KEY_W-1 -: RK_W];
            win_q     <= key_i;
            hold_q    <= {key_i[RK_W-1 -: 2*WORD_W], {(2*WORD_W){1'b0}}};
            rcon_q    <= 8'h01;
            cnt_q     <= '0;
            final_q   <= '0;
            final_v_q <= 1'b0;
            unique case (ksize_i)
                KS_192:  last_idx_q <= LAST_192;
                KS_256:  last_idx_q <= LAST_256;
                default: last_idx_q <= LAST_128;
            endcase
        end else if (take && !rk_last) begin
            rk_q  <= nxt_rk;
            cnt_q <= cnt_nxt;
            if (cnt_nxt == last_idx_q) begin
                final_q   <= nxt_rk;
                final_v_q <= 1'b1;
            end
            unique case (state_q)
                ST_K128: rcon_q <= gf_dbl(rcon_q);
                ST_K256_ROT: begin
                    win_q[KEY_W-1 -: RK_W] <= rk_q;
                    rcon_q <= gf_dbl(rcon_q);
                end
                ST_K256_SUB: win_q[KEY_W-1 -: RK_W] <= rk_q;
                ST_K192_P1: begin
                    hold_q <= c6[RK_W-1:0];
                    win_q[KEY_W-1 -: C6_W] <= c6;
                    rcon_q <= gf_dbl(rcon_q);
                end
                ST_K192_P0: begin
                    hold_q[RK_W-1 -: 2*WORD_W] <= c6[2*WORD_W-1:0];
                    win_q[KEY_W-1 -: C6_W] <= c6;
                    rcon_q <= gf_dbl(rcon_q);
                end
                default: ;
            endcase
        end
    end

    assign rk_o          = rk_q;
    assign rk_valid_o    = rk_valid;
    assign rk_last_o     = rk_last;
    assign final_key_o   = final_q;
    assign final_valid_o = final_v_q;

    // R1: key count stays within the selected schedule length
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rk_valid_o |-> (cnt_q <= last_idx_q) &&
                       ((last_idx_q == LAST_128) || (last_idx_q == LAST_192) || (last_idx_q == LAST_256)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid_o && advance_i && !rk_last_o && !load_i) |=> (rk_valid_o && cnt_q == $past(cnt_nxt)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid_o && !advance_i && !load_i) |=> (rk_valid_o && $stable(rk_o)));

    p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rk_valid_o && rk_last_o && advance_i && !load_i) |=> !rk_valid_o);

    p_final_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rk_last_o |-> (final_valid_o && final_key_o == rk_o));

    p_final_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (final_valid_o && !load_i) |=> (final_valid_o && $stable(final_key_o)));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rk_valid_o && !final_valid_o && cnt_q == '0));

endmodule

// File: tb/tb_aes_key_sched.sv
`timescale 1ns/1ps
module tb_aes_key_sched;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] key_i = '0;
    logic [1:0]   ksize_i = 2'b00;
    logic         load_i = 1'b0;
    logic         advance_i = 1'b0;
    logic [127:0] rk_o, final_key_o;
    logic         rk_valid_o, rk_last_o, final_valid_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [7:0]  sb [256];
    logic [31:0] mw [60];
    int          mn;

    always #4 clk = ~clk;

    aes_key_sched dut (
        .clk(clk), .rst_n(rst_n), .key_i(key_i), .ksize_i(ksize_i),
        .load_i(load_i), .advance_i(advance_i), .rk_o(rk_o),
        .rk_valid_o(rk_valid_o), .rk_last_o(rk_last_o),
        .final_key_o(final_key_o), .final_valid_o(final_valid_o)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rl(input logic [7:0] x, input int k);
        logic [15:0] d;
        d = {x, x} << k;
        return d[15:8];
    endfunction

    // substitution table built by walking generator 3 and its inverse
    task automatic build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        do begin
            p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    function automatic logic [31:0] subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    function automatic logic [127:0] refk(input int i);
        return {mw[4*i], mw[4*i+1], mw[4*i+2], mw[4*i+3]};
    endfunction

    task automatic model(input logic [255:0] k, input logic [1:0] ks);
        int nk;
        logic [31:0] t;
        logic [7:0] rc;
        nk = (ks == 2'b01) ? 6 : (ks == 2'b10) ? 8 : 4;
        mn = nk + 7;
        for (int i = 0; i < nk; i++) mw[i] = k[255-32*i -: 32];
        rc = 8'h01;
        for (int i = nk; i < 4*mn; i++) begin
            t = mw[i-1];
            if (i % nk == 0) begin
                t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
            end else if (nk == 8 && i % nk == 4) begin
                t = subw(t);
            end
            mw[i] = mw[i-nk] ^ t;
        end
    endtask

    task automatic do_load(input logic [255:0] k, input logic [1:0] ks, input logic adv);
        key_i = k; ksize_i = ks; load_i = 1'b1; advance_i = adv;
        @(negedge clk);
        load_i = 1'b0; advance_i = 1'b0;
        model(k, ks);
        chk(rk_valid_o && rk_o == k[255:128], "R2 first key after load", rk_o, k[255:128]);
        chk(!final_valid_o, "R10 final cleared by load", {127'b0, final_valid_o}, 128'b0);
    endtask

    task automatic walk(input int pct, input int stop, input string req);
        int i = 0;
        bit adv;
        while (i < stop) begin
            chk(rk_valid_o, "R3 valid during schedule", {127'b0, rk_valid_o}, 128'd1);
            chk(rk_o == refk(i), req, rk_o, refk(i));
            chk(rk_last_o == (i == mn-1), "R5 last flag", {127'b0, rk_last_o}, {127'b0, (i == mn-1)});
            if (i == mn-1)
                chk(final_valid_o && final_key_o == refk(i), "R9 final key with last", final_key_o, refk(i));
            adv = (($urandom % 100) < pct);
            advance_i = adv;
            @(negedge clk);
            if (adv) i++;
        end
        advance_i = 1'b0;
        if (stop == mn) begin
            chk(!rk_valid_o, "R5 valid drops after last", {127'b0, rk_valid_o}, 128'b0);
            chk(final_valid_o && final_key_o == refk(mn-1), "R9 final key held", final_key_o, refk(mn-1));
            advance_i = 1'b1;
            repeat (2) @(negedge clk);
            advance_i = 1'b0;
            chk(!rk_valid_o && final_key_o == refk(mn-1), "R5 advance after end ignored", final_key_o, refk(mn-1));
        end
    endtask

    function automatic logic [255:0] rnd_key();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [1:0] ks;
        void'($urandom(32'h1234_5eed));
        build_sbox();
        repeat (3) @(negedge clk);
        chk(!rk_valid_o && !rk_last_o && !final_valid_o, "R11 reset outputs",
            {125'b0, rk_valid_o, rk_last_o, final_valid_o}, 128'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rk_valid_o, "R11 idle after reset", {127'b0, rk_valid_o}, 128'b0);

        // directed known AES-128 vector
        do_load({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'b00, 1'b0);
        walk(100, mn, "R6 AES-128 round key");
        chk(mn == 11, "R1 128-bit key count", 128'(mn), 128'd11);
        chk(final_key_o == 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R6 known last key",
            final_key_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

        // random keys, all size codes, random advance density
        for (int t = 0; t < 24; t++) begin
            ks = 2'(t % 4);
            do_load(rnd_key(), ks, 1'b0);
            case (ks)
                2'b01:   walk(30 + (t * 7) % 71, mn, "R7 AES-192 round key");
                2'b10:   walk(30 + (t * 7) % 71, mn, "R8 AES-256 round key");
                default: walk(30 + (t * 7) % 71, mn, "R6 AES-128 round key (R1 code 11 as 00)");
            endcase
            chk(mn == ((ks == 2'b01) ? 13 : (ks == 2'b10) ? 15 : 11), "R1 key count", 128'(mn), 128'(mn));
        end

        // restart in the middle of a 192-bit schedule with advance high
        do_load(rnd_key(), 2'b01, 1'b0);
        walk(100, 5, "R7 partial 192 schedule");
        do_load(rnd_key(), 2'b10, 1'b1);
        walk(100, mn, "R10 schedule after restart");

        finish_run();
    end
endmodule